// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Reader

This block reads one measurement frame from a temperature and humidity sensor that shares a single open-drain data line with the controller. A one-cycle `start` pulse in idle makes the block pull the line low for a timed wake-up pulse and then release it. After a short counted release window, the block follows the sensor's acknowledge handshake. It then times the high phase of each of 40 data bits to decide between 0 and 1. When the last bit has been captured, the block presents the five bytes, reports whether the checksum byte matches, and raises a ready flag.

The controller never drives the line high. `line_oe` asks an external pad to pull the line to 0, and at all other times the pull-up or the sensor owns it. The line value passes through a chain of flip-flops before any decision uses it. Waits on the sensor are bounded by a timeout. If a wait runs too long, the read is abandoned and a timeout flag is raised in place of the ready flag.

Top module: `hygro_reader`

## Requirements
- R1: After `start` is sampled high in idle, `line_oe` is 1 from the next cycle on, for exactly START_CYC cycles (1000 at the default 1 MHz clock, 1 ms). It is 0 at every other time.
- R2: `line_in` passes through SYNC_STAGES flops (default 2). A level sampled at clock edge k is acted on by the state machine at edge k+2.
- R3: After `line_oe` falls, a counted window of REL_CYC cycles (20) passes. Any line activity inside that window has no effect on the frame that follows.
- R4: After the window, the block waits for the line to go low, then high, then low (the acknowledge). Only after that does it start decoding bits.
- R5: Each bit is a low phase followed by a high phase. The high phase is counted in cycles from the cycle after the synchronized rise. A count of at least THR_CYC (40) when the synchronized line falls decodes as 1, and a smaller count decodes as 0. Bits enter MSB first, so `frame_data[39]` holds the first bit received.
- R6: On the capture of the 40th bit, `frame_data` is updated and `data_ready` is set in the same cycle. `sum_ok` is 1 when (frame[39:32]+frame[31:24]+frame[23:16]+frame[15:8]) mod 256 equals frame[7:0].
- R7: A start that is accepted clears `data_ready` and `timeout` in the next cycle. `frame_data` and `sum_ok` keep their previous values until a new frame completes.
- R8: `start` has no effect while a read is in progress. In particular it does not re-assert `line_oe`.
- R9: If any wait on the line lasts TO_CYC cycles (200) without the awaited level, the read ends. `timeout` becomes 1, the block returns to idle, and `data_ready` stays 0.
- R10: If the awaited level arrives in the last cycle of the timeout window, the handshake proceeds and no timeout is raised.
- R11: After reset, `line_oe`, `data_ready`, `timeout`, `sum_ok` and `frame_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request one read; sampled only in idle |
| line_in | input | 1 | Raw level of the shared data line |
| line_oe | output | 1 | 1 = pull the line to 0; 0 = leave it released |
| frame_data | output | NBITS (40) | Last complete frame, first bit received in the MSB |
| sum_ok | output | 1 | Checksum of the last complete frame matched |
| data_ready | output | 1 | A complete frame is held in `frame_data` |
| timeout | output | 1 | The last read was abandoned on a wait limit |

## Verification
Two events can fall in the same cycle: a wait state's timeout limit and the arrival of the level that state waits for. The bench provokes this by holding the acknowledge low phase for lengths that sweep across the 200-cycle limit, so that one length puts the synchronized rise exactly on the last cycle of the window. A behavioural model fed with the same line waveform predicts every output on every clock. A separate check then confirms that `timeout` stays low for lengths up to the limit and rises only for longer ones.

// File: rtl/hygro_pkg.sv
package hygro_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a request
    S_PULSE,  // pulling the line low
    S_REL,    // counted release window
    S_WLO,    // wait for the sensor to pull low
    S_WHI,    // wait for the acknowledge high phase
    S_WEND,   // wait for the end of the acknowledge
    S_BLO,    // bit low phase
    S_BHI     // bit high phase, being measured
  } rd_state_e;

  // microseconds to clock cycles, rounded down
  function automatic int unsigned us2cyc(input int unsigned clk_hz, input int unsigned us);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(us);
    return int'(prod / 64'd1000000);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hygro_rst_sync.sv
module hygro_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);

  logic r1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      r1    <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      r1    <= 1'b1;
      rst_q <= r1;
    end
  end

endmodule

// File: rtl/hygro_sync.sv
module hygro_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hygro_timer.sv
module hygro_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  logic         inc_en;
  logic [W-1:0] cnt_d;

  assign inc_en = (cnt != {W{1'b1}});

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (inc_en) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/hygro_frame.sv
module hygro_frame #(
  parameter int NBITS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             commit,
  output logic [NBITS-1:0] frame,
  output logic             sum_ok
);

  localparam int NBYTES = NBITS / 8;

  logic [NBITS-2:0] shreg;
  logic [NBITS-1:0] nxt_frame;
  logic [7:0]       acc;

  assign nxt_frame = {shreg, bit_in};

  // byte 0 is the check byte, the others are summed modulo 256
  always_comb begin
    acc = '0;
    for (int i = 1; i < NBYTES; i++) begin
      acc = acc + nxt_frame[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (shift_en) begin
      shreg <= nxt_frame[NBITS-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame  <= '0;
      sum_ok <= 1'b0;
    end else if (commit) begin
      frame  <= nxt_frame;
      sum_ok <= (acc == nxt_frame[7:0]);
    end
  end

endmodule

// File: rtl/hygro_reader.sv
module hygro_reader
  import hygro_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 1_000_000,
  parameter int unsigned START_US    = 1000,
  parameter int unsigned REL_US      = 20,
  parameter int unsigned THR_US      = 40,
  parameter int unsigned TO_US       = 200,
  parameter int          SYNC_STAGES = 2,
  parameter int          NBITS       = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             line_in,
  output logic             line_oe,
  output logic [NBITS-1:0] frame_data,
  output logic             sum_ok,
  output logic             data_ready,
  output logic             timeout
);

  localparam int unsigned START_CYC = us2cyc(CLK_HZ, START_US);
  localparam int unsigned REL_CYC   = us2cyc(CLK_HZ, REL_US);
  localparam int unsigned THR_CYC   = us2cyc(CLK_HZ, THR_US);
  localparam int unsigned TO_CYC    = us2cyc(CLK_HZ, TO_US);
  localparam int unsigned MAX_CYC   = umax(START_CYC, TO_CYC);
  localparam int          CW        = $clog2(MAX_CYC + 1);
  localparam int          BW        = $clog2(NBITS + 1);

  logic          rst_q;
  logic          ln;
  logic [CW-1:0] tcnt;
  logic          tclr;
  rd_state_e     st, st_d;
  logic [BW-1:0] bcnt;
  logic          accept, cap, fin, abort, to_hit, bit_val;

  hygro_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_q  (rst_q)
  );

  hygro_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     (line_in),
    .q     (ln)
  );

  hygro_timer #(
    .W (CW)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (tclr),
    .cnt   (tcnt)
  );

  assign to_hit  = (tcnt == CW'(TO_CYC - 1));
  assign bit_val = (tcnt >= CW'(THR_CYC));

  // next-state logic
  always_comb begin
    st_d   = st;
    accept = 1'b0;
    cap    = 1'b0;
    fin    = 1'b0;
    abort  = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (start) begin
          st_d   = S_PULSE;
          accept = 1'b1;
        end
      end
      S_PULSE: begin
        if (tcnt == CW'(START_CYC - 1)) st_d = S_REL;
      end
      S_REL: begin
        if (tcnt == CW'(REL_CYC - 1)) st_d = S_WLO;
      end
      S_WLO: begin
        if (!ln)        st_d  = S_WHI;
        else if (to_hit) abort = 1'b1;
      end
      S_WHI: begin
        if (ln)          st_d  = S_WEND;
        else if (to_hit) abort = 1'b1;
      end
      S_WEND: begin
        if (!ln)         st_d  = S_BLO;
        else if (to_hit) abort = 1'b1;
      end
      S_BLO: begin
        if (ln)          st_d  = S_BHI;
        else if (to_hit) abort = 1'b1;
      end
      S_BHI: begin
        if (!ln) begin
          cap = 1'b1;
          if (bcnt == BW'(1)) begin
            fin  = 1'b1;
            st_d = S_IDLE;
          end else begin
            st_d = S_BLO;
          end
        end else if (to_hit) begin
          abort = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (abort) st_d = S_IDLE;
  end

  assign tclr = (st_d != st);

  // state and control registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st <= S_IDLE;
    end else begin
      st <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bcnt <= '0;
    end else if (accept) begin
      bcnt <= BW'(NBITS);
    end else if (cap) begin
      bcnt <= bcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      data_ready <= 1'b0;
      timeout    <= 1'b0;
    end else if (accept) begin
      data_ready <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      if (fin)   data_ready <= 1'b1;
      if (abort) timeout    <= 1'b1;
    end
  end

  assign line_oe = (st == S_PULSE);

  hygro_frame #(
    .NBITS (NBITS)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_q),
    .shift_en (cap),
    .bit_in   (bit_val),
    .commit   (fin),
    .frame    (frame_data),
    .sum_ok   (sum_ok)
  );

  // R1: the pull only begins after a request
  assert_oe_after_start_R1: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(line_oe) |-> $past(start));

  // R1: the pull ends when the timer has covered the full pulse
  assert_oe_width_R1: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(line_oe) |-> ($past(tcnt) == CW'(START_CYC - 1)));

  // R7: flags are cleared by an accepted request
  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_q)
    accept |=> (!data_ready && !timeout));

  // R9: a read never ends both complete and timed out
  assert_ready_timeout_excl_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !(data_ready && timeout));

  // R6: ready only rises on the capture of the last bit
  assert_ready_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(data_ready) |-> ($past(bcnt) == BW'(1)));

  // R9: an abandoned read leaves the line released and flags a timeout
  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_q)
    abort |=> (timeout && !line_oe && !data_ready));

endmodule

// File: tb/test_hygro_reader.sv
module test_hygro_reader;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 40;
  localparam int START = 1000;
  localparam int REL   = 20;
  localparam int THR   = 40;
  localparam int TO    = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic line_in = 1'b1;
  logic sens_rel = 1'b1;

  logic          line_oe;
  logic [NB-1:0] frame_data;
  logic          sum_ok;
  logic          data_ready;
  logic          timeout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hygro_reader i_hygro_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .line_in    (line_in),
    .line_oe    (line_oe),
    .frame_data (frame_data),
    .sum_ok     (sum_ok),
    .data_ready (data_ready),
    .timeout    (timeout)
  );

  // wired-AND bus: controller pull or sensor pull makes it low
  always @(negedge clk) line_in <= (!line_oe) && sens_rel;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic csum_good(input logic [39:0] f);
    logic [7:0] s;
    s = f[39:32] + f[31:24] + f[23:16] + f[15:8];
    return s == f[7:0];
  endfunction

  // ---------------- behavioural reference model ----------------
  int   m_ph, m_tm, m_bits, m_rdly;
  logic m_s1, m_s2, m_s;
  logic [39:0] m_sh, m_data;
  logic m_ok, m_rdy, m_to;

  always @(posedge clk or negedge rst_n) begin
    int  nph;
    bit  ab;
    if (!rst_n) begin
      m_ph = 0; m_tm = 0; m_bits = 0; m_rdly = 0;
      m_s1 = 1'b1; m_s2 = 1'b1; m_s = 1'b1;
      m_sh = '0; m_data = '0; m_ok = 1'b0; m_rdy = 1'b0; m_to = 1'b0;
    end else if (m_rdly < 2) begin
      m_rdly++;
    end else begin
      m_s = m_s2; m_s2 = m_s1; m_s1 = line_in;
      nph = m_ph; ab = 1'b0;
      case (m_ph)
        0: if (start) begin nph = 1; m_rdy = 1'b0; m_to = 1'b0; m_bits = 0; end
        1: if (m_tm == START-1) nph = 2;
        2: if (m_tm == REL-1) nph = 3;
        3: if (!m_s) nph = 4; else if (m_tm == TO-1) ab = 1'b1;
        4: if (m_s)  nph = 5; else if (m_tm == TO-1) ab = 1'b1;
        5: if (!m_s) nph = 6; else if (m_tm == TO-1) ab = 1'b1;
        6: if (m_s)  nph = 7; else if (m_tm == TO-1) ab = 1'b1;
        7: begin
          if (!m_s) begin
            m_sh = {m_sh[38:0], (m_tm >= THR)};
            m_bits++;
            if (m_bits == NB) begin
              m_data = m_sh; m_ok = csum_good(m_sh); m_rdy = 1'b1; nph = 0;
            end else begin
              nph = 6;
            end
          end else if (m_tm == TO-1) ab = 1'b1;
        end
        default: nph = 0;
      endcase
      if (ab) begin nph = 0; m_to = 1'b1; end
      m_tm = (nph != m_ph) ? 0 : m_tm + 1;
      m_ph = nph;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk("R1", "line_oe", 64'(line_oe), 64'(m_ph == 1));
      chk("R5", "frame_data", 64'(frame_data), 64'(m_data));
      chk("R6", "sum_ok", 64'(sum_ok), 64'(m_ok));
      chk("R2/R6", "data_ready", 64'(data_ready), 64'(m_rdy));
      chk("R2/R9", "timeout", 64'(timeout), 64'(m_to));
    end
  end

  // line_oe activity monitors
  int  oe_cycles = 0;
  int  oe_rises = 0;
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (line_oe) oe_cycles++;
    if (line_oe && !oe_prev) oe_rises++;
    oe_prev = line_oe;
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    sens_rel = v;
    wait_cyc(n);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_release();
    @(negedge clk);
    while (!line_oe) @(negedge clk);
    while (line_oe) @(negedge clk);
  endtask

  // sensor side: stop_after < NB leaves the line high after that many bits
  task automatic sensor_frame(input logic [39:0] f, input int stop_after, input bit glitch);
    wait_release();
    if (glitch) begin
      hold(1'b1, 3); hold(1'b0, 5); hold(1'b1, 17);
    end else begin
      hold(1'b1, 25);
    end
    hold(1'b0, 80); hold(1'b1, 80);
    for (int i = 39; i >= 0; i--) begin
      hold(1'b0, 50);
      if ((39 - i) == stop_after) begin
        hold(1'b1, 300);
        return;
      end
      hold(1'b1, f[i] ? 70 : 26);
    end
    hold(1'b0, 50);
    sens_rel = 1'b1;
  endtask

  localparam logic [39:0] F1 = 40'h028C015FEE;
  localparam logic [39:0] F2 = 40'h55AA0F3312;
  localparam logic [39:0] F3 = 40'hFFFFFFFFFC;
  localparam logic [39:0] F4 = 40'h0000000000;

  initial begin : main
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R11: reset values
    chk("R11", "line_oe", 64'(line_oe), 64'd0);
    chk("R11", "data_ready", 64'(data_ready), 64'd0);
    chk("R11", "timeout", 64'(timeout), 64'd0);
    chk("R11", "sum_ok", 64'(sum_ok), 64'd0);
    chk("R11", "frame_data", 64'(frame_data), 64'd0);
    cmp_on = 1'b1;

    // normal frame with valid checksum
    oe_cycles = 0;
    fork
      sensor_frame(F1, NB, 1'b0);
      do_start();
    join
    wait_cyc(5);
    chk("R1", "pulse length", 64'(oe_cycles), 64'(START));
    chk("R4", "handshake then data", 64'(frame_data), 64'(F1));
    chk("R5", "frame bits", 64'(frame_data), 64'(F1));
    chk("R6", "ready", 64'(data_ready), 64'd1);
    chk("R6", "checksum good", 64'(sum_ok), 64'd1);

    // new request clears ready, keeps data; bad checksum frame
    fork
      sensor_frame(F2, NB, 1'b0);
      begin
        do_start();
        chk("R7", "ready cleared", 64'(data_ready), 64'd0);
        chk("R7", "data kept", 64'(frame_data), 64'(F1));
        chk("R7", "sum kept", 64'(sum_ok), 64'd1);
      end
    join
    wait_cyc(5);
    chk("R6", "frame F2", 64'(frame_data), 64'(F2));
    chk("R6", "checksum bad", 64'(sum_ok), 64'(csum_good(F2)));
    chk("R6", "ready F2", 64'(data_ready), 64'd1);

    // start while busy is ignored
    oe_rises = 0;
    fork
      sensor_frame(F3, NB, 1'b0);
      begin
        do_start();
        wait_cyc(3000);
        do_start();
      end
    join
    wait_cyc(5);
    chk("R8", "single pulse", 64'(oe_rises), 64'd1);
    chk("R8", "frame F3", 64'(frame_data), 64'(F3));
    chk("R8", "ready F3", 64'(data_ready), 64'd1);

    // activity inside the release window is ignored
    fork
      sensor_frame(F4, NB, 1'b1);
      do_start();
    join
    wait_cyc(5);
    chk("R3", "frame F4", 64'(frame_data), 64'(F4));
    chk("R3", "ready F4", 64'(data_ready), 64'd1);
    chk("R3", "timeout F4", 64'(timeout), 64'd0);

    // no response at all
    do_start();
    wait_cyc(START + REL + TO + 50);
    chk("R9", "no response timeout", 64'(timeout), 64'd1);
    chk("R9", "no response ready", 64'(data_ready), 64'd0);
    chk("R9", "no response data", 64'(frame_data), 64'(F4));
    chk("R9", "no response oe", 64'(line_oe), 64'd0);

    // stall in a bit high phase
    fork
      sensor_frame(F1, 10, 1'b0);
      do_start();
    join
    wait_cyc(10);
    chk("R9", "stall timeout", 64'(timeout), 64'd1);
    chk("R9", "stall ready", 64'(data_ready), 64'd0);

    // acknowledge low length swept across the limit
    for (int d = -3; d <= 2; d++) begin
      fork
        begin
          wait_release();
          hold(1'b1, 25);
          hold(1'b0, TO + d);
          sens_rel = 1'b1;
          wait_cyc(10);
          chk("R10", "timeout at limit", 64'(timeout), 64'(d > 0));
          wait_cyc(400);
        end
        do_start();
      join
      chk("R2", "abandoned at end", 64'(timeout), 64'd1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule